// File: doc/BRIEF.md
# Paged External Bus Controller

This block connects a small 8-bit processor core to an external bus shared by scratchpad memory and peripheral ports. The core presents a request carrying an operation code, an 8-bit location and a write byte. Loads, stores, port inputs and port outputs each become one bus transaction with address, write data and separate read and write strobes. Memory and ports use the same path; an I/O qualifier output tells them apart.

Every transaction keeps its strobe active for at least three clock cycles. From the third strobe cycle on, the slave's ready input is sampled in each cycle. Each cycle in which ready is low adds one more cycle. The 8-bit location from the core reaches only 256 addresses. The bits above it come from a page register that a dedicated page operation writes, so the bus address can be from 8 to 24 bits wide. The core is stalled while a transaction is in flight. It receives a one-cycle done pulse together with the captured read byte.

Top module: `pxb_ctrl`

## Requirements
- R1: Out of reset, both strobes, the stall and the done outputs are low, the read-data output is 0 and the page register is 0.
- R2: A request with op 1 (load) or 3 (port input) in an idle cycle raises the read strobe from the next cycle. Op 2 (store) or 4 (port output) raises the write strobe instead. The I/O qualifier is high only for ops 3 and 4. The bus address is the page register in bits AW-1..8 and the request location in bits 7..0.
- R3: A strobe stays high for at least three cycles. Ready is ignored during its first two cycles.
- R4: From the third strobe cycle on, the strobe ends after the first cycle in which ready is sampled high. Each cycle in which ready is low extends the transaction by one cycle.
- R5: The read byte on the bus is captured at the end of the cycle in which ready ends a read. The read-data output holds that value until the next read completes; stores and port outputs leave it unchanged.
- R6: Address, write data, the I/O qualifier and the strobes stay stable for the whole transaction.
- R7: The stall output is high in the request cycle and in every strobe cycle. It is low in the cycle after the last strobe cycle.
- R8: The done output pulses high for exactly one cycle, the cycle after the last strobe cycle.
- R9: Op 5 (set page) in an idle cycle loads the page register from the low AW-8 bits of {write byte, location}. It starts no bus transaction, does not stall, and its value persists across later accesses.
- R10: A request presented while a transaction is in progress is not taken. A set-page request during that time leaves the page register unchanged.
- R11: Ops 0, 6 and 7 have no effect: no strobe, no stall, page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_req | input | 1 | Core request valid |
| core_op | input | 3 | Operation code (0 none, 1 load, 2 store, 3 port in, 4 port out, 5 set page) |
| core_loc | input | 8 | Location within the page; low bits of page value for op 5 |
| core_wbyte | input | 8 | Write byte; high bits of page value for op 5 |
| core_stall | output | 1 | Core must hold off |
| core_done | output | 1 | One-cycle completion pulse |
| core_rbyte | output | 8 | Last byte read |
| bus_addr | output | AW | External address |
| bus_wdata | output | 8 | External write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | High for port accesses, low for scratchpad |
| bus_ready | input | 1 | Slave transaction-complete input |
| bus_rdata | input | 8 | External read data |

## Verification
A wrong phase count in the sequencer changes the strobe length at once. Ready seen too early cuts a transaction to one or two cycles. A stuck count never ends it. Either shows at the strobe pins within the same transaction, and also as a done pulse arriving a cycle early or late. A corrupted page register, or one written while busy, shows in the upper address bits on the first strobe cycle of the next access. A misplaced capture edge shows as a wrong read byte in the done cycle.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_STORE = 3'd2,
    OP_PIN   = 3'd3,
    OP_POUT  = 3'd4,
    OP_PAGE  = 3'd5
  } pxb_op_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic io;
  } pxb_kind_t;

  function automatic logic op_is_bus(input logic [2:0] op);
    return (op == OP_LOAD) || (op == OP_STORE) || (op == OP_PIN) || (op == OP_POUT);
  endfunction

  function automatic pxb_kind_t op_kind(input logic [2:0] op);
    pxb_kind_t k;
    k.rd = (op == OP_LOAD)  || (op == OP_PIN);
    k.wr = (op == OP_STORE) || (op == OP_POUT);
    k.io = (op == OP_PIN)   || (op == OP_POUT);
    return k;
  endfunction

  function automatic logic [15:0] page_value(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/pxb_page.sv
module pxb_page #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [15:0]   value,
  input  logic [7:0]    loc,
  output logic [AW-1:0] addr
);

  localparam int PW = AW - 8;

  generate
    if (PW > 0) begin : g_paged
      logic [PW-1:0] page_q;

      always_ff @(posedge clk) begin
        if (!rst_n)   page_q <= '0;
        else if (load) page_q <= value[PW-1:0];
      end

      assign addr = {page_q, loc};
    end else begin : g_flat
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst_n, load, value};
      assign addr = loc[AW-1:0];
    end
  endgenerate

endmodule

// File: rtl/pxb_seq.sv
module pxb_seq #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready,
  output logic busy,
  output logic min_met,
  output logic finish
);

  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_CYC);

  typedef enum logic {S_IDLE, S_XFER} seq_st_e;

  seq_st_e       st_q;
  logic [CW-1:0] phase_q;

  assign busy    = (st_q == S_XFER);
  assign min_met = busy && (phase_q >= MIN_V);
  assign finish  = min_met && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      phase_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start) begin
            st_q    <= S_XFER;
            phase_q <= CW'(1);
          end
        end
        default: begin
          if (finish) begin
            st_q    <= S_IDLE;
            phase_q <= '0;
          end else if (phase_q < MIN_V) begin
            phase_q <= phase_q + CW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/pxb_dpath.sv
module pxb_dpath
  import pxb_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  pxb_kind_t     kind,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    wbyte_in,
  input  logic          finish,
  input  logic [7:0]    bus_rdata,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  output logic          done,
  output logic [7:0]    rbyte
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_io    <= 1'b0;
      done      <= 1'b0;
      rbyte     <= '0;
    end else begin
      done <= finish;
      if (start) begin
        bus_addr  <= addr_in;
        bus_wdata <= wbyte_in;
        bus_rd    <= kind.rd;
        bus_wr    <= kind.wr;
        bus_io    <= kind.io;
      end else if (finish) begin
        bus_rd <= 1'b0;
        bus_wr <= 1'b0;
        if (bus_rd) rbyte <= bus_rdata;
      end
    end
  end

endmodule

// File: rtl/pxb_ctrl.sv
module pxb_ctrl
  import pxb_pkg::*;
#(
  parameter int AW      = 16,
  parameter int MIN_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic [2:0]    core_op,
  input  logic [7:0]    core_loc,
  input  logic [7:0]    core_wbyte,
  output logic          core_stall,
  output logic          core_done,
  output logic [7:0]    core_rbyte,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          bus_io,
  input  logic          bus_ready,
  input  logic [7:0]    bus_rdata
);

  logic          busy;
  logic          min_met;
  logic          xfer_finish;
  logic          acc_start;
  logic          page_load;
  logic [AW-1:0] next_addr;
  pxb_kind_t     kind;

  assign acc_start  = core_req && !busy && op_is_bus(core_op);
  assign page_load  = core_req && !busy && (core_op == OP_PAGE);
  assign kind       = op_kind(core_op);
  assign core_stall = busy || acc_start;

  pxb_page #(.AW(AW)) u_page (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (page_load),
    .value (page_value(core_wbyte, core_loc)),
    .loc   (core_loc),
    .addr  (next_addr)
  );

  pxb_seq #(.MIN_CYC(MIN_CYC)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (acc_start),
    .ready   (bus_ready),
    .busy    (busy),
    .min_met (min_met),
    .finish  (xfer_finish)
  );

  pxb_dpath #(.AW(AW)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (acc_start),
    .kind      (kind),
    .addr_in   (next_addr),
    .wbyte_in  (core_wbyte),
    .finish    (xfer_finish),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_io    (bus_io),
    .done      (core_done),
    .rbyte     (core_rbyte)
  );

endmodule

// File: rtl/pxb_ctrl_chk.sv
module pxb_ctrl_chk #(
  parameter int AW      = 16,
  parameter int MIN_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic          bus_io,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_ready,
  input logic          core_stall,
  input logic          core_done,
  input logic          acc_start,
  input logic          page_load
);

  logic       strb;
  logic [7:0] len_q;

  assign strb = bus_rd || bus_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)             len_q <= '0;
    else if (!strb)         len_q <= '0;
    else if (len_q != 8'hFF) len_q <= len_q + 8'd1;
  end

  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  a_r3_min_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb) |-> (len_q >= 8'(MIN_CYC)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    strb && (!bus_ready || (len_q < 8'(MIN_CYC - 1))) |=> strb);

  a_r6_stable: assert property (@(posedge clk) disable iff (!rst_n)
    strb && $past(strb) |-> $stable(bus_addr) && $stable(bus_wdata) &&
                            $stable(bus_io) && $stable(bus_rd));

  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    strb |-> core_stall);

  a_r8_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb) |-> core_done);

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    core_done |=> !core_done);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> !strb);

  a_r9_page_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    page_load |=> !strb);

endmodule

bind pxb_ctrl pxb_ctrl_chk #(.AW(AW), .MIN_CYC(MIN_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_io     (bus_io),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready),
  .core_stall (core_stall),
  .core_done  (core_done),
  .acc_start  (acc_start),
  .page_load  (page_load)
);

// File: tb/pxb_ctrl_tb.sv
`timescale 1ns/1ps
module pxb_ctrl_tb;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_req = 1'b0;
  logic [2:0]    core_op = 3'd0;
  logic [7:0]    core_loc = 8'd0;
  logic [7:0]    core_wbyte = 8'd0;
  logic          core_stall, core_done;
  logic [7:0]    core_rbyte;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_rd, bus_wr, bus_io;
  logic          bus_ready = 1'b0;
  logic [7:0]    bus_rdata = 8'd0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] exp_page = 8'd0;
  logic [7:0] exp_rbyte = 8'd0;

  always #5 clk = ~clk;

  pxb_ctrl #(.AW(AW), .MIN_CYC(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_req(core_req), .core_op(core_op),
    .core_loc(core_loc), .core_wbyte(core_wbyte), .core_stall(core_stall),
    .core_done(core_done), .core_rbyte(core_rbyte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rd strobe in reset", bus_rd, 0);
    chk("R1", "wr strobe in reset", bus_wr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "stall after reset", core_stall, 0);
    chk("R1", "done after reset", core_done, 0);
    chk("R1", "rbyte after reset", core_rbyte, 0);
    chk("R1", "strobes after reset", {bus_rd, bus_wr}, 0);
  endtask

  // rdy_from: first strobe cycle with ready high; early: also high in cycles 1..2
  task automatic t_access(input logic [2:0] op, input logic [7:0] loc,
                          input logic [7:0] wb, input bit early, input int rdy_from,
                          input logic [7:0] rval, input bit poke);
    bit is_rd, is_wr, is_io;
    int kend;
    is_rd = (op == 3'd1) || (op == 3'd3);
    is_wr = (op == 3'd2) || (op == 3'd4);
    is_io = (op == 3'd3) || (op == 3'd4);
    kend  = (rdy_from < 3) ? 3 : rdy_from;
    @(negedge clk);
    core_req = 1'b1; core_op = op; core_loc = loc; core_wbyte = wb;
    bus_ready = 1'b0;
    #1;
    chk("R7", "stall in request cycle", core_stall, 1);
    @(posedge clk);
    for (int k = 1; k <= kend; k++) begin
      @(negedge clk);
      if (k == 1) core_req = 1'b0;
      if (poke && k == 2) begin
        core_req = 1'b1; core_op = 3'd5; core_loc = 8'h3C;
      end
      if (poke && k == 3) core_req = 1'b0;
      bus_ready = (k >= rdy_from) || (early && k < 3);
      bus_rdata = (k == kend) ? rval : (~rval ^ 8'(k));
      chk(is_rd ? "R2" : "R3", "read strobe", bus_rd, is_rd);
      chk(is_wr ? "R2" : "R4", "write strobe", bus_wr, is_wr);
      if (k == 1) begin
        chk("R2", "address", bus_addr, {exp_page, loc});
        chk("R2", "io qualifier", bus_io, is_io);
      end
      if (k == kend) begin
        chk("R6", "address held", bus_addr, {exp_page, loc});
        if (is_wr) chk("R6", "write data held", bus_wdata, wb);
      end
      chk("R7", "stall in strobe cycle", core_stall, 1);
      chk("R8", "done low while busy", core_done, 0);
    end
    @(negedge clk);
    bus_ready = 1'b0;
    if (is_rd) exp_rbyte = rval;
    chk("R4", "strobes end after ready", {bus_rd, bus_wr}, 0);
    chk("R8", "done pulse", core_done, 1);
    chk("R7", "stall released", core_stall, 0);
    chk("R5", "read byte", core_rbyte, exp_rbyte);
    @(negedge clk);
    chk("R8", "done one cycle", core_done, 0);
    core_op = 3'd0;
  endtask

  task automatic t_page(input logic [7:0] val);
    @(negedge clk);
    core_req = 1'b1; core_op = 3'd5; core_loc = val; core_wbyte = 8'hEE;
    #1;
    chk("R9", "no stall on set page", core_stall, 0);
    @(negedge clk);
    core_req = 1'b0; core_op = 3'd0;
    chk("R9", "no strobe on set page", {bus_rd, bus_wr}, 0);
    chk("R9", "no done on set page", core_done, 0);
    exp_page = val;
  endtask

  task automatic t_inert(input logic [2:0] op);
    @(negedge clk);
    core_req = 1'b1; core_op = op; core_loc = 8'h99; core_wbyte = 8'h77;
    #1;
    chk("R11", "no stall on inert op", core_stall, 0);
    @(negedge clk);
    core_req = 1'b0; core_op = 3'd0;
    chk("R11", "no strobe on inert op", {bus_rd, bus_wr}, 0);
    chk("R11", "no done on inert op", core_done, 0);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    join_none
    t_reset();
    t_page(8'hA5);                                        // R9
    t_access(3'd1, 8'h12, 8'h00, 1'b0, 3, 8'h5A, 1'b0);   // R2 R3 R5 load, ready at third cycle
    t_access(3'd2, 8'h34, 8'hC3, 1'b0, 5, 8'h11, 1'b0);   // R4 R5 store stretched, rbyte unchanged
    t_access(3'd3, 8'h56, 8'h00, 1'b1, 3, 8'h9E, 1'b0);   // R3 early ready ignored, port input
    t_access(3'd4, 8'h78, 8'h4B, 1'b1, 7, 8'h22, 1'b0);   // R4 R6 long stretch, port output
    t_inert(3'd6);                                        // R11
    t_inert(3'd0);                                        // R11
    t_access(3'd1, 8'hF0, 8'h00, 1'b0, 4, 8'hC7, 1'b1);   // R10 set-page during busy
    t_access(3'd3, 8'h01, 8'h00, 1'b0, 1, 8'h3D, 1'b0);   // R10 R11 page still A5
    t_page(8'h07);                                        // R9 new page
    t_access(3'd1, 8'hFF, 8'h00, 1'b0, 6, 8'h80, 1'b0);   // R9 R4 address uses new page
    t_access(3'd2, 8'h00, 8'hFE, 1'b1, 2, 8'h00, 1'b0);   // R3 ready in cycle 2 only counts at 3
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule